// File: doc/BRIEF.md
# Zero-Copy Buffer Ownership Switch

This block manages a pool of equal RAM buffers shared by two domains: a packet-side engine and a parallel I/O side. Every buffer belongs to exactly one domain at any moment. A buffer changes hands only through ring pointers, so the words stay where they are and no data is ever copied.

The pool is split into endpoints. Each endpoint takes one to four consecutive buffers and arranges them as a ring. One domain fills buffers as the producer, and the other domain drains them as the consumer. A producer commit hands the current buffer to the consumer together with a byte count. A consumer commit (a release) hands the oldest buffer back to the producer.

The endpoint layout is sampled from configuration inputs while reset is held. Per-endpoint empty and full flags are visible to both domains. On the packet side a buffer is seen as single-port memory. On the I/O side a buffer is seen as dual-port memory, with separate write and read addresses.

Top module: `bufpool_switch`

## Requirements
- R1: During and after reset, every endpoint reports empty=1 and full=0, and both byte-count outputs read 0.
- R2: A producer commit is accepted when the producer has a free buffer. The endpoint's empty flag goes low on the clock after the commit cycle.
- R3: Endpoint e takes its depth from cfg_depth[2e+1:2e], encoded as depth minus 1 (0..3 means single to quad). Its buffers start right after those of endpoints 0..e-1. The full flag rises on the clock after the commit that gives the consumer all depth buffers.
- R4: A producer commit on a full endpoint is ignored. Flags stay the same, and neither the stored byte count nor the ring order changes.
- R5: A release on an empty endpoint is ignored, and the endpoint stays empty.
- R6: Words written by the producer appear to the consumer at the same addresses after commit, because the buffer itself changes owner. Read data appears one clock after the read address.
- R7: The consumer's byte-count output shows the count of its oldest committed buffer, registered one clock after that buffer becomes current. Buffers are consumed in commit order.
- R8: When a commit and a release hit the same endpoint in one cycle, both take effect. Occupancy and flags stay unchanged, and the ring advances on both sides.
- R9: A write from a domain that holds no buffer of the addressed endpoint leaves memory unchanged. No buffer is ever written by both domains in one cycle.
- R10: When cfg_dir[e] is 0 the packet side produces for endpoint e. When it is 1 the I/O side produces and the packet side consumes.
- R11: A domain that holds no buffer of its selected endpoint reads data 0 and byte count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| cfg_depth | input | 2*NUM_EP | Per-endpoint depth minus one |
| cfg_dir | input | NUM_EP | Per-endpoint producer select (0 packet, 1 I/O) |
| pkt_ep | input | EPW | Packet-side endpoint select |
| pkt_commit | input | 1 | Packet-side commit (hand over buffer) |
| pkt_count | input | CW | Byte count sent with a packet-side producer commit |
| pkt_we | input | 1 | Packet-side write enable |
| pkt_addr | input | AW | Packet-side word address (shared by read and write) |
| pkt_wdata | input | DW | Packet-side write data |
| pkt_rdata | output | DW | Packet-side read data, one clock after address |
| pkt_cnt | output | CW | Byte count of the buffer the packet side consumes |
| io_ep | input | EPW | I/O-side endpoint select |
| io_commit | input | 1 | I/O-side commit |
| io_count | input | CW | Byte count sent with an I/O-side producer commit |
| io_we | input | 1 | I/O-side write enable |
| io_waddr | input | AW | I/O-side write address |
| io_wdata | input | DW | I/O-side write data |
| io_raddr | input | AW | I/O-side read address |
| io_rdata | output | DW | I/O-side read data, one clock after address |
| io_cnt | output | CW | Byte count of the buffer the I/O side consumes |
| ep_empty | output | NUM_EP | Per-endpoint empty flag |
| ep_full | output | NUM_EP | Per-endpoint full flag |

## Verification
A producer commit and a consumer release can reach the same endpoint ring in the same clock. The bench provokes this by raising both domains' commit strobes together on a double-buffered endpoint that already holds one committed buffer. It then requires that neither flag moves and that the consumer's count output switches to the buffer committed in that cycle. The same collision is also judged at the ring boundary: a commit on a full ring is dropped, and the later drain must still return the original counts in the original order.

// File: rtl/bufpool_pkg.sv
package bufpool_pkg;
  localparam int IDX_W = 2;  // ring index width, up to quad buffering

  function automatic logic [IDX_W:0] ring_depth(input logic [IDX_W-1:0] dm1);
    return {1'b0, dm1} + 1'b1;
  endfunction
endpackage

// File: rtl/bufpool_ring.sv
module bufpool_ring
  import bufpool_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] depth_m1,
  input  logic             prod_req,
  input  logic             cons_req,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             prod_room,
  output logic             cons_has,
  output logic             prod_acc,
  output logic             full_q,
  output logic             empty_q
);
  logic [IDX_W:0] occ, occ_nxt, depth;
  logic           cons_acc;

  assign depth     = ring_depth(depth_m1);
  assign prod_room = (occ != depth);
  assign cons_has  = (occ != '0);
  assign prod_acc  = prod_req && prod_room;
  assign cons_acc  = cons_req && cons_has;

  always_comb begin
    occ_nxt = occ;
    if (prod_acc && !cons_acc) occ_nxt = occ + 1'b1;
    if (!prod_acc && cons_acc) occ_nxt = occ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ     <= '0;
      wr_idx  <= '0;
      rd_idx  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      occ     <= occ_nxt;
      full_q  <= (occ_nxt == depth);
      empty_q <= (occ_nxt == '0);
      if (prod_acc) wr_idx <= (wr_idx == depth_m1) ? '0 : wr_idx + 1'b1;
      if (cons_acc) rd_idx <= (rd_idx == depth_m1) ? '0 : rd_idx + 1'b1;
    end
  end

  p_occ_cap_r3: assert property (@(posedge clk) disable iff (rst) occ <= depth);
  p_flag_excl_r3: assert property (@(posedge clk) disable iff (rst) !(full_q && empty_q));
  p_flag_lag_r2: assert property (@(posedge clk) disable iff (rst)
    prod_acc && !cons_req |=> !empty_q);
  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    prod_req && !prod_room && !cons_req |=> full_q && $stable(wr_idx));
  p_empty_drop_r5: assert property (@(posedge clk) disable iff (rst)
    cons_req && !cons_has && !prod_req |=> empty_q && $stable(rd_idx));
  p_swap_r8: assert property (@(posedge clk) disable iff (rst)
    prod_acc && cons_acc |=> $stable(occ) && $stable(full_q) && $stable(empty_q));
endmodule

// File: rtl/bufpool_bank.sv
module bufpool_bank #(
  parameter int WORDS = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bufpool_switch.sv
module bufpool_switch
  import bufpool_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int NUM_EP  = 4,
  parameter int WORDS   = 256,
  parameter int DW      = 16,
  localparam int AW     = $clog2(WORDS),
  localparam int BW     = $clog2(NUM_BUF),
  localparam int EPW    = $clog2(NUM_EP),
  localparam int CW     = $clog2(WORDS * DW / 8) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NUM_EP-1:0]   cfg_depth,
  input  logic [NUM_EP-1:0]     cfg_dir,
  input  logic [EPW-1:0]        pkt_ep,
  input  logic                  pkt_commit,
  input  logic [CW-1:0]         pkt_count,
  input  logic                  pkt_we,
  input  logic [AW-1:0]         pkt_addr,
  input  logic [DW-1:0]         pkt_wdata,
  output logic [DW-1:0]         pkt_rdata,
  output logic [CW-1:0]         pkt_cnt,
  input  logic [EPW-1:0]        io_ep,
  input  logic                  io_commit,
  input  logic [CW-1:0]         io_count,
  input  logic                  io_we,
  input  logic [AW-1:0]         io_waddr,
  input  logic [DW-1:0]         io_wdata,
  input  logic [AW-1:0]         io_raddr,
  output logic [DW-1:0]         io_rdata,
  output logic [CW-1:0]         io_cnt,
  output logic [NUM_EP-1:0]     ep_empty,
  output logic [NUM_EP-1:0]     ep_full
);
  logic [2*NUM_EP-1:0] dep_q;
  logic [NUM_EP-1:0]   dir_q;
  logic [BW:0]         base [NUM_EP];
  logic [IDX_W-1:0]    wr_idx [NUM_EP];
  logic [IDX_W-1:0]    rd_idx [NUM_EP];
  logic [BW-1:0]       prod_buf [NUM_EP];
  logic [BW-1:0]       cons_buf [NUM_EP];
  logic [NUM_EP-1:0]   prod_room, cons_has, prod_acc;
  logic [CW-1:0]       cnt [NUM_BUF];
  logic [DW-1:0]       bank_q [NUM_BUF];

  // configuration is captured while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      dep_q <= cfg_depth;
      dir_q <= cfg_dir;
    end
  end

  always_comb begin
    base[0] = '0;
    for (int e = 1; e < NUM_EP; e++)
      base[e] = base[e-1] + {{(BW-1){1'b0}}, dep_q[2*(e-1) +: 2]} + 1'b1;
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic pkt_hit_ep, io_hit_ep;
    assign pkt_hit_ep = pkt_commit && (pkt_ep == EPW'(e));
    assign io_hit_ep  = io_commit && (io_ep == EPW'(e));

    bufpool_ring u_ring (
      .clk      (clk),
      .rst      (rst),
      .depth_m1 (dep_q[2*e +: 2]),
      .prod_req (dir_q[e] ? io_hit_ep : pkt_hit_ep),
      .cons_req (dir_q[e] ? pkt_hit_ep : io_hit_ep),
      .wr_idx   (wr_idx[e]),
      .rd_idx   (rd_idx[e]),
      .prod_room(prod_room[e]),
      .cons_has (cons_has[e]),
      .prod_acc (prod_acc[e]),
      .full_q   (ep_full[e]),
      .empty_q  (ep_empty[e])
    );

    assign prod_buf[e] = base[e][BW-1:0] + BW'(wr_idx[e]);
    assign cons_buf[e] = base[e][BW-1:0] + BW'(rd_idx[e]);
  end

  // byte counts travel with the buffer they describe
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BUF; b++) cnt[b] <= '0;
    end else begin
      for (int e = 0; e < NUM_EP; e++)
        if (prod_acc[e]) cnt[prod_buf[e]] <= dir_q[e] ? io_count : pkt_count;
    end
  end

  // buffer each domain currently reaches through its endpoint select
  logic          pkt_prod, io_prod, pkt_ok, io_ok, pkt_ok_q, io_ok_q;
  logic [BW-1:0] pkt_buf, io_buf, pkt_sel_q, io_sel_q;

  assign pkt_prod = !dir_q[pkt_ep];
  assign io_prod  = dir_q[io_ep];
  assign pkt_buf  = pkt_prod ? prod_buf[pkt_ep] : cons_buf[pkt_ep];
  assign io_buf   = io_prod ? prod_buf[io_ep] : cons_buf[io_ep];
  assign pkt_ok   = pkt_prod ? prod_room[pkt_ep] : cons_has[pkt_ep];
  assign io_ok    = io_prod ? prod_room[io_ep] : cons_has[io_ep];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_bank
    logic pkt_hit, io_hit;
    assign pkt_hit = pkt_ok && (pkt_buf == BW'(b));
    assign io_hit  = io_ok && (io_buf == BW'(b));

    bufpool_bank #(.WORDS(WORDS), .DW(DW)) u_bank (
      .clk  (clk),
      .we   ((pkt_hit && pkt_we) || (io_hit && io_we)),
      .waddr(io_hit ? io_waddr : pkt_addr),
      .wdata(io_hit ? io_wdata : pkt_wdata),
      .raddr(io_hit ? io_raddr : pkt_addr),
      .rdata(bank_q[b])
    );

    p_one_owner_r9: assert property (@(posedge clk) disable iff (rst) !(pkt_hit && io_hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_ok_q  <= 1'b0;
      io_ok_q   <= 1'b0;
      pkt_sel_q <= '0;
      io_sel_q  <= '0;
      pkt_cnt   <= '0;
      io_cnt    <= '0;
    end else begin
      pkt_ok_q  <= pkt_ok;
      io_ok_q   <= io_ok;
      pkt_sel_q <= pkt_buf;
      io_sel_q  <= io_buf;
      pkt_cnt   <= (!pkt_prod && pkt_ok) ? cnt[pkt_buf] : '0;
      io_cnt    <= (!io_prod && io_ok) ? cnt[io_buf] : '0;
    end
  end

  assign pkt_rdata = pkt_ok_q ? bank_q[pkt_sel_q] : '0;
  assign io_rdata  = io_ok_q ? bank_q[io_sel_q] : '0;

  p_no_orphan_read_r11: assert property (@(posedge clk) disable iff (rst)
    !io_ok |=> io_rdata == '0);
  p_cnt_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !pkt_ok |=> pkt_cnt == '0);
endmodule

// File: tb/bufpool_switch_test.sv
module bufpool_switch_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [7:0]  cfg_depth;
  logic [3:0]  cfg_dir;
  logic [1:0]  pkt_ep, io_ep;
  logic        pkt_commit, io_commit, pkt_we, io_we;
  logic [9:0]  pkt_count, io_count, pkt_cnt, io_cnt;
  logic [7:0]  pkt_addr, io_waddr, io_raddr;
  logic [15:0] pkt_wdata, io_wdata, pkt_rdata, io_rdata;
  logic [3:0]  ep_empty, ep_full;

  bufpool_switch uut (.*);

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // one commit strobe from one domain, returns at the next falling edge
  task automatic commit(input logic dom, input logic [1:0] ep, input logic [9:0] c);
    if (dom) begin io_ep = ep; io_count = c; io_commit = 1'b1; end
    else     begin pkt_ep = ep; pkt_count = c; pkt_commit = 1'b1; end
    @(negedge clk);
    io_commit = 1'b0;
    pkt_commit = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] d, input logic [3:0] dr);
    rst = 1'b1; cfg_depth = d; cfg_dir = dr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // {dom, ep, count, -, exp_empty, exp_full}; default layout: ep0 quad, ep1 double
  localparam logic [15:0] VEC [11] = '{
    {1'b0, 2'd1, 10'd10,  1'b0, 1'b0, 1'b0},
    {1'b0, 2'd1, 10'd20,  1'b0, 1'b0, 1'b1},
    {1'b0, 2'd1, 10'd30,  1'b0, 1'b0, 1'b1},
    {1'b1, 2'd1, 10'd0,   1'b0, 1'b0, 1'b0},
    {1'b1, 2'd1, 10'd0,   1'b0, 1'b1, 1'b0},
    {1'b1, 2'd1, 10'd0,   1'b0, 1'b1, 1'b0},
    {1'b0, 2'd0, 10'd100, 1'b0, 1'b0, 1'b0},
    {1'b0, 2'd0, 10'd101, 1'b0, 1'b0, 1'b0},
    {1'b0, 2'd0, 10'd102, 1'b0, 1'b0, 1'b0},
    {1'b0, 2'd0, 10'd103, 1'b0, 1'b0, 1'b1},
    {1'b0, 2'd0, 10'd104, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pkt_ep = 0; io_ep = 0; pkt_commit = 0; io_commit = 0; pkt_count = 0; io_count = 0;
    pkt_we = 0; io_we = 0; pkt_addr = 0; io_waddr = 0; io_raddr = 0;
    pkt_wdata = 0; io_wdata = 0;
    @(negedge clk);
    do_reset(8'b00_00_01_11, 4'b0000);

    // R1 reset state
    chk("R1 empty", ep_empty, 4'hF);
    chk("R1 full", ep_full, 4'h0);
    chk("R1 pkt_cnt", pkt_cnt, 0);
    chk("R1 io_cnt", io_cnt, 0);

    // R2 R3 R4 R5 vector walk
    for (int i = 0; i < 11; i++) begin
      commit(VEC[i][15], VEC[i][14:13], VEC[i][12:3]);
      chk($sformatf("R2/R3 vec%0d empty R4 R5", i), ep_empty[VEC[i][14:13]], VEC[i][1]);
      chk($sformatf("R3 vec%0d full", i), ep_full[VEC[i][14:13]], VEC[i][0]);
    end

    // R7 drain ep0 in order; R4: dropped 104 must not overwrite 100
    io_ep = 2'd0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk($sformatf("R7 R4 count order %0d", k), io_cnt, 100 + k);
      commit(1'b1, 2'd0, 10'd0);
    end
    chk("R5 ep0 drained", ep_empty[0], 1'b1);
    @(negedge clk);
    chk("R11 io_cnt on empty", io_cnt, 0);

    // R8 commit and release together on ep1
    commit(1'b0, 2'd1, 10'd50);
    io_ep = 2'd1; io_commit = 1'b1;
    pkt_ep = 2'd1; pkt_count = 10'd60; pkt_commit = 1'b1;
    @(negedge clk);
    io_commit = 1'b0; pkt_commit = 1'b0;
    chk("R8 empty stays", ep_empty[1], 1'b0);
    chk("R8 full stays", ep_full[1], 1'b0);
    @(negedge clk);
    chk("R8 consumer sees new buffer", io_cnt, 60);
    commit(1'b1, 2'd1, 10'd0);
    chk("R8 drained", ep_empty[1], 1'b1);

    // R6 R9 R11 zero-copy on single-buffered ep2
    pkt_ep = 2'd2; pkt_addr = 8'd5; pkt_wdata = 16'hBEEF; pkt_we = 1'b1;
    @(negedge clk);
    pkt_we = 1'b0;
    commit(1'b0, 2'd2, 10'd2);
    chk("R3 single full", ep_full[2], 1'b1);
    io_ep = 2'd2; io_raddr = 8'd5;
    @(negedge clk);
    chk("R6 data handed over", io_rdata, 16'hBEEF);
    pkt_addr = 8'd5; pkt_wdata = 16'h1111; pkt_we = 1'b1;
    @(negedge clk);
    pkt_we = 1'b0;
    @(negedge clk);
    chk("R9 foreign write blocked", io_rdata, 16'hBEEF);
    chk("R11 pkt read without buffer", pkt_rdata, 0);

    // R10 swapped direction, triple-buffered ep0
    do_reset(8'b00_00_00_10, 4'b0001);
    for (int k = 0; k < 4; k++) begin
      commit(1'b1, 2'd0, 10'd7 + 10'(k));
      chk($sformatf("R10 R3 triple full %0d", k), ep_full[0], k >= 2);
    end
    pkt_ep = 2'd0;
    @(negedge clk);
    chk("R10 pkt consumes count", pkt_cnt, 7);
    commit(1'b1, 2'd1, 10'd0);
    chk("R5 R10 io release on empty ep1", ep_empty[1], 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule